// File: doc/BRIEF.md
# Multi-Channel External Bus Controller

The controller sits between an on-chip host and an external asynchronous bus that serves ROM, SRAM, flash and plain I/O devices. Eight channels are configured separately through a small register port. Each channel has a base address, a window size, a device data width, a clock divisor and four timing fields. A host request is matched against the eight windows. The matching channel's chip select then frames one or more external read or write cycles, and their timing follows that channel's settings.

When the host asks for 32 bits from a 16-bit or 8-bit device, the controller splits the access into two or four external cycles. The lower bytes go first, at ascending addresses, and the narrow pieces are reassembled into one host word. Sub-cycles whose byte enables are all zero do not run. The host holds its request until it sees a one-cycle acknowledge, which carries the read data or an error flag.

The sequencer has seven states:
- IDLE accepts a request.
- PICK chooses the next sub-cycle that has enabled lanes.
- ASU is address setup, with the chip select inactive.
- CSU is chip-select setup.
- STRB is the active read or write strobe.
- HOLD keeps the chip select and address after the strobe.
- DONE acknowledges.

Its transitions are:
- IDLE→PICK on a hit.
- IDLE→DONE on a miss.
- PICK→ASU, CSU or STRB, whichever is the first phase with a non-zero length.
- ASU→CSU or STRB.
- CSU→STRB.
- STRB→HOLD, or STRB→PICK when the hold is zero.
- HOLD→PICK.
- PICK→DONE when no enabled sub-cycle remains.
- DONE→IDLE.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Eight active-low chip selects `ext_cs_n`. At most one is low at any time, and the low one is always the channel that was selected for the access in progress. All are high after reset.
- R2: Configuration word 0 of a channel (`cfg_word_sel`=0) has the fields enable [0], width [2:1] (0=32, 1=16, 2/3=8 bits), divisor code [4:3], size code s [8:5] and base [31:20]. The window of a channel is the 2^(20+s)-byte region aligned on that size and containing the base. When windows overlap, the lowest-numbered channel wins.
- R3: The size code is capped according to the channel width: at most 10 for a 32-bit channel, 9 for 16-bit and 8 for 8-bit. A larger code acts as the cap.
- R4: An access that hits no enabled window is acknowledged with `host_err`=1, and no chip select or strobe is asserted. After reset every channel is disabled.
- R5: A host access to a 16-bit channel runs as up to two external cycles, at byte offsets 0 and 2. To an 8-bit channel it runs as up to four, at offsets 0 to 3. `ext_addr` is the word address plus that offset. Data and lane enables (`ext_be_n`) use the low lanes.
- R6: A sub-cycle whose host byte enables are all zero produces no strobe. Read bytes that are not enabled return zero.
- R7: A tick lasts (divisor code + 1) clocks.
- R8: Configuration word 1 (`cfg_word_sel`=1) has the fields address setup [1:0], chip-select setup [3:2], strobe width [7:4] and hold [9:8], all counted in ticks. The chip select is low for csu ticks before the strobe. The strobe is low for max(width,1) ticks. The chip select stays low for hold ticks after the strobe and goes high between sub-cycles. The two strobes are never low together.
- R9: Read data is sampled in the last clock of the strobe phase, and the assembled word is presented together with the acknowledge.
- R10: `ext_dq_oe` is high only during write accesses, and for the whole time the chip select is low in them.
- R11: A channel's settings are captured when an access is accepted. A configuration write during an access affects only later accesses.
- R12: `host_ack` is a single-cycle pulse. The host keeps `host_req` high until it sees the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel being configured |
| cfg_word_sel | input | 1 | 0 = decode word, 1 = timing word |
| cfg_wdata | input | 32 | Configuration data |
| host_req | input | 1 | Host request, held until acknowledge |
| host_we | input | 1 | 1 = write |
| host_addr | input | 32 | Byte address |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables |
| host_ack | output | 1 | One-cycle completion |
| host_err | output | 1 | No channel hit, valid with acknowledge |
| host_rdata | output | 32 | Assembled read data |
| ext_addr | output | 32 | External byte address |
| ext_cs_n | output | 8 | Chip selects, active low |
| ext_oe_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write strobe, active low |
| ext_be_n | output | 4 | Lane enables, active low |
| ext_dout | output | 32 | Write data |
| ext_dq_oe | output | 1 | Data bus drive enable |
| ext_din | input | 32 | Read data from the bus |

## Verification
The hardest case is a configuration change that lands in the middle of a running external cycle. It occurs only when a register write is timed against a sequence that the host cannot see. The bench forks a configuration write a few clocks after a request is issued, and the new strobe width is far from the old one. The strobe width it then measures must still equal the old value. Partial byte enables on 8-bit and 16-bit channels are also hard to reach at random, so they are driven directly; they check that sub-cycles are skipped and that offsets still ascend.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int WIN_LSB = 20;
    localparam int BASE_W = ADDR_W - WIN_LSB;

    typedef struct packed {
        logic              en;
        logic [1:0]        bw;
        logic [1:0]        div;
        logic [3:0]        sz;
        logic [BASE_W-1:0] base;
        logic [1:0]        asu;
        logic [1:0]        csu;
        logic [3:0]        stw;
        logic [1:0]        hld;
    } chcfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PICK, S_ASU, S_CSU, S_STRB, S_HOLD, S_DONE
    } st_e;

    function automatic logic [3:0] max_sz(input logic [1:0] bw);
        case (bw)
            2'd0:    return 4'd10;
            2'd1:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [2:0] sub_count(input logic [1:0] bw);
        case (bw)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] byte_off(input logic [1:0] bw, input logic [1:0] k);
        case (bw)
            2'd0:    return 2'd0;
            2'd1:    return {k[0], 1'b0};
            default: return k;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] bw,
                                                   input logic [LANES-1:0] be,
                                                   input logic [1:0] k);
        case (bw)
            2'd0:    return (k == 2'd0) ? be : '0;
            2'd1:    return (k[1] == 1'b0) ? {2'b00, be[{k[0], 1'b0} +: 2]} : '0;
            default: return {3'b000, be[k]};
        endcase
    endfunction
endpackage

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
    import ebc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       chan,
    input  logic                word_sel,
    input  logic [DATA_W-1:0]   wdata,
    output chcfg_t [NCH-1:0]    cfg
);
    for (genvar c = 0; c < NCH; c++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[c] <= '0;
            end else if (we && chan == IW'(c)) begin
                if (!word_sel) begin
                    cfg[c].en   <= wdata[0];
                    cfg[c].bw   <= wdata[2:1];
                    cfg[c].div  <= wdata[4:3];
                    cfg[c].sz   <= wdata[8:5];
                    cfg[c].base <= wdata[ADDR_W-1:WIN_LSB];
                end else begin
                    cfg[c].asu <= wdata[1:0];
                    cfg[c].csu <= wdata[3:2];
                    cfg[c].stw <= wdata[7:4];
                    cfg[c].hld <= wdata[9:8];
                end
            end
        end
    end
endmodule

// File: rtl/ebc_decode.sv
module ebc_decode
    import ebc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  chcfg_t [NCH-1:0]  cfg,
    output logic              hit,
    output logic [IW-1:0]     idx
);
    logic [NCH-1:0] hv;

    for (genvar c = 0; c < NCH; c++) begin : g_win
        logic [3:0]        s_eff;
        logic [BASE_W-1:0] keep;
        assign s_eff = (cfg[c].sz > max_sz(cfg[c].bw)) ? max_sz(cfg[c].bw) : cfg[c].sz;
        assign keep  = ~((BASE_W'(1) << s_eff) - BASE_W'(1));
        assign hv[c] = cfg[c].en &&
                       (((addr[ADDR_W-1:WIN_LSB] ^ cfg[c].base) & keep) == '0);
    end

    always_comb begin
        hit = |hv;
        idx = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (hv[c]) idx = IW'(c);
        end
    end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH),
    localparam int LW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic              hit,
    input  logic [IW-1:0]     hit_idx,
    input  chcfg_t            hit_cfg,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [NCH-1:0]    ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [LANES-1:0]  ext_be_n,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_dq_oe,
    input  logic [DATA_W-1:0] ext_din
);
    st_e                 state, nxt;
    logic [ADDR_W-3:0]   a_r;
    logic                we_r, err_r;
    logic [DATA_W-1:0]   wd_r, rd_acc;
    logic [LANES-1:0]    be_r, lm;
    chcfg_t              cfg_r;
    logic [IW-1:0]       idx_r;
    logic [2:0]          sub_r;
    logic [LW-1:0]       cnt, l_asu, l_csu, l_stb, l_hld, l_cur;
    logic [2:0]          tck;
    logic [1:0]          off, fk;
    logic                found, last, cs_on;

    assign tck   = {1'b0, cfg_r.div} + 3'd1;
    assign l_asu = LW'(cfg_r.asu) * LW'(tck);
    assign l_csu = LW'(cfg_r.csu) * LW'(tck);
    assign l_stb = LW'((cfg_r.stw == 4'd0) ? 4'd1 : cfg_r.stw) * LW'(tck);
    assign l_hld = LW'(cfg_r.hld) * LW'(tck);
    assign off   = byte_off(cfg_r.bw, sub_r[1:0]);
    assign lm    = lane_mask(cfg_r.bw, be_r, sub_r[1:0]);

    always_comb begin
        found = 1'b0;
        fk    = '0;
        for (int k = 3; k >= 0; k--) begin
            if (k >= int'(sub_r) && k < int'(sub_count(cfg_r.bw)) &&
                lane_mask(cfg_r.bw, be_r, 2'(k)) != '0) begin
                found = 1'b1;
                fk    = 2'(k);
            end
        end
    end

    always_comb begin
        unique case (state)
            S_ASU:   l_cur = l_asu;
            S_CSU:   l_cur = l_csu;
            S_STRB:  l_cur = l_stb;
            S_HOLD:  l_cur = l_hld;
            default: l_cur = LW'(1);
        endcase
    end
    assign last = (cnt == l_cur - LW'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req) nxt = hit ? S_PICK : S_DONE;
            S_PICK: begin
                if (!found)              nxt = S_DONE;
                else if (l_asu != '0)    nxt = S_ASU;
                else if (l_csu != '0)    nxt = S_CSU;
                else                     nxt = S_STRB;
            end
            S_ASU:  if (last) nxt = (l_csu != '0) ? S_CSU : S_STRB;
            S_CSU:  if (last) nxt = S_STRB;
            S_STRB: if (last) nxt = (l_hld != '0) ? S_HOLD : S_PICK;
            S_HOLD: if (last) nxt = S_PICK;
            S_DONE: nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            a_r    <= '0;
            we_r   <= 1'b0;
            err_r  <= 1'b0;
            wd_r   <= '0;
            be_r   <= '0;
            cfg_r  <= '0;
            idx_r  <= '0;
            sub_r  <= '0;
            rd_acc <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + LW'(1);
            if (state == S_IDLE && req) begin
                a_r    <= addr[ADDR_W-1:2];
                we_r   <= we;
                wd_r   <= wdata;
                be_r   <= be;
                cfg_r  <= hit_cfg;
                idx_r  <= hit_idx;
                err_r  <= !hit;
                sub_r  <= '0;
                rd_acc <= '0;
            end
            if (state == S_PICK && found) sub_r <= {1'b0, fk};
            if ((state == S_STRB || state == S_HOLD) && nxt == S_PICK) sub_r <= sub_r + 3'd1;
            if (state == S_STRB && last && !we_r) begin
                for (int i = 0; i < LANES; i++) begin
                    if (lm[i] && (int'(off) + i) < LANES)
                        rd_acc[8*(int'(off)+i) +: 8] <= ext_din[8*i +: 8];
                end
            end
        end
    end

    // outputs
    always_comb begin
        cs_on    = 1'b0;
        ext_oe_n = 1'b1;
        ext_we_n = 1'b1;
        unique case (state)
            S_CSU, S_HOLD: cs_on = 1'b1;
            S_STRB: begin
                cs_on    = 1'b1;
                ext_oe_n = we_r;
                ext_we_n = !we_r;
            end
            S_IDLE, S_PICK, S_ASU, S_DONE: cs_on = 1'b0;
        endcase
        ext_cs_n = '1;
        if (cs_on) ext_cs_n[idx_r] = 1'b0;
        ext_dq_oe = cs_on && we_r;
    end

    assign ext_addr = {a_r, off};
    assign ext_dout = wd_r >> {off, 3'b000};
    assign ext_be_n = ~lm;
    assign ack      = (state == S_DONE);
    assign err      = ack && err_r;
    assign rdata    = rd_acc;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n)); // R8
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_oe_n || !ext_we_n) |-> !(&ext_cs_n)); // R8
    AST_STROBE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we_n && $past(!ext_we_n)) |-> $stable(ext_addr)); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (&ext_cs_n)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R12
    AST_DQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we_n) |-> ext_dq_oe); // R10
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_chan,
    input  logic              cfg_word_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_be,
    output logic              host_ack,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [NCH-1:0]    ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic [LANES-1:0]  ext_be_n,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_dq_oe,
    input  logic [DATA_W-1:0] ext_din
);
    chcfg_t [NCH-1:0] cfg;
    logic             hit;
    logic [IW-1:0]    hit_idx;

    ebc_cfg_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .chan(cfg_chan),
        .word_sel(cfg_word_sel), .wdata(cfg_wdata), .cfg(cfg)
    );

    ebc_decode #(.NCH(NCH)) u_dec (
        .addr(host_addr), .cfg(cfg), .hit(hit), .idx(hit_idx)
    );

    ebc_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(host_req), .we(host_we),
        .addr(host_addr), .wdata(host_wdata), .be(host_be),
        .hit(hit), .hit_idx(hit_idx), .hit_cfg(cfg[hit_idx]),
        .ack(host_ack), .err(host_err), .rdata(host_rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_be_n(ext_be_n), .ext_dout(ext_dout),
        .ext_dq_oe(ext_dq_oe), .ext_din(ext_din)
    );
endmodule

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_word_sel = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic [31:0] cfg_wdata = '0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_ack, host_err, ext_oe_n, ext_we_n, ext_dq_oe;
    logic [31:0] host_rdata, ext_addr, ext_dout, ext_din;
    logic [7:0]  ext_cs_n;
    logic [3:0]  ext_be_n;

    always #4 clk = ~clk;

    ext_bus_ctrl dut (.*);

    int n_cmp = 0, n_bad = 0;
    int sh_en[8], sh_bw[8], sh_div[8], sh_sz[8], sh_base[8];
    int sh_asu[8], sh_csu[8], sh_stw[8], sh_hld[8];
    logic [7:0] dev_mem [0:1023];
    logic [7:0] ref_mem [0:1023];
    int exp_cs = -1, exp_csu = 0, exp_hld = 0, exp_w = 0, exp_n = 0, nstb = 0;
    int exp_off[4];
    bit acc_we = 1'b0;
    logic [31:0] acc_base = '0;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int dev_of(input logic [7:0] csn);
        for (int i = 0; i < 8; i++) if (!csn[i]) return i;
        return 0;
    endfunction

    // external device model
    always_comb begin
        for (int i = 0; i < 4; i++)
            ext_din[8*i +: 8] = dev_mem[{3'(dev_of(ext_cs_n)), 7'(ext_addr[6:0] + 7'(i))}];
    end
    always @(posedge clk) begin
        if (!ext_we_n)
            for (int i = 0; i < 4; i++)
                if (!ext_be_n[i])
                    dev_mem[{3'(dev_of(ext_cs_n)), 7'(ext_addr[6:0] + 7'(i))}] <= ext_dout[8*i +: 8];
    end

    // bus monitor
    bit prev_stb = 1'b0, seen = 1'b0;
    int pre = 0, post = 0, wcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit stb = !ext_oe_n || !ext_we_n;
            automatic bit csa = !(&ext_cs_n);
            if (ext_dq_oe && !acc_we) chk(0, "R10 dq_oe in read", 1, 0);
            if (csa && acc_we && !ext_dq_oe) chk(0, "R10 dq_oe missing", 0, 1);
            if (stb && !prev_stb) begin
                chk(exp_cs >= 0 && ext_cs_n == ~(8'd1 << exp_cs), "R1 cs", ext_cs_n, ~(8'd1 << exp_cs));
                chk(nstb < exp_n, "R6 extra strobe", nstb, exp_n);
                if (nstb < exp_n)
                    chk(ext_addr == acc_base + 32'(exp_off[nstb]), "R5 addr", ext_addr, acc_base + 32'(exp_off[nstb]));
                chk(pre == exp_csu, "R8 cs setup", pre, exp_csu);
                nstb++;
                seen = 1'b1;
                wcnt = 0;
            end
            if (stb) wcnt++;
            if (!stb && prev_stb) chk(wcnt == exp_w, "R7 strobe width", wcnt, exp_w);
            if (csa && !stb) begin
                if (seen) post++; else pre++;
            end
            if (!csa) begin
                if (seen) chk(post == exp_hld, "R8 hold", post, exp_hld);
                pre = 0; post = 0; seen = 1'b0;
            end
            prev_stb = stb;
        end
    end

    task automatic cfg_write(input int c, input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 3'(c); cfg_word_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_chan(input int c, input int en, input int bw, input int dv, input int sz,
                            input int base, input int asu, input int csu, input int stw, input int hld);
        sh_en[c] = en; sh_bw[c] = bw; sh_div[c] = dv; sh_sz[c] = sz; sh_base[c] = base;
        sh_asu[c] = asu; sh_csu[c] = csu; sh_stw[c] = stw; sh_hld[c] = hld;
        cfg_write(c, 1'b0, 32'(en) | 32'(bw) << 1 | 32'(dv) << 3 | 32'(sz) << 5 | 32'(base) << 20);
        cfg_write(c, 1'b1, 32'(asu) | 32'(csu) << 2 | 32'(stw) << 4 | 32'(hld) << 8);
    endtask

    function automatic int find_ch(input logic [31:0] a);
        for (int c = 0; c < 8; c++) begin
            int cap = (sh_bw[c] == 0) ? 10 : (sh_bw[c] == 1) ? 9 : 8;
            int s = (sh_sz[c] > cap) ? cap : sh_sz[c];
            if (sh_en[c] != 0 && ((int'(a[31:20]) ^ sh_base[c]) >> s) == 0) return c;
        end
        return -1;
    endfunction

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input logic [3:0] be);
        int c = find_ch(a);
        logic [31:0] exp_rd = '0;
        int guard = 0;
        acc_we = we; exp_n = 0; nstb = 0; exp_cs = c;
        acc_base = {a[31:2], 2'b00};
        if (c >= 0) begin
            int tk = sh_div[c] + 1;
            int nb = (sh_bw[c] == 0) ? 4 : (sh_bw[c] == 1) ? 2 : 1;
            exp_csu = sh_csu[c] * tk;
            exp_hld = sh_hld[c] * tk;
            exp_w = ((sh_stw[c] == 0) ? 1 : sh_stw[c]) * tk;
            for (int off = 0; off < 4; off += nb)
                if (((int'(be) >> off) & ((1 << nb) - 1)) != 0) begin
                    exp_off[exp_n] = off; exp_n++;
                end
            for (int j = 0; j < 4; j++)
                if (be[j]) begin
                    if (we) ref_mem[{3'(c), a[6:2], 2'(j)}] = wd[8*j +: 8];
                    else exp_rd[8*j +: 8] = ref_mem[{3'(c), a[6:2], 2'(j)}];
                end
        end
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd; host_be = be;
        do begin
            @(negedge clk);
            guard++;
        end while (!host_ack && guard < 2000);
        host_req = 1'b0;
        chk(host_ack, "R12 ack seen", host_ack, 1);
        chk(host_err == (c < 0), "R4 err", host_err, c < 0);
        if (!we && c >= 0) chk(host_rdata == exp_rd, "R9 rdata", host_rdata, exp_rd);
        chk(nstb == exp_n, "R5 strobe count", nstb, exp_n);
        @(negedge clk);
        chk(!host_ack, "R12 single pulse", host_ack, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4937));
        for (int i = 0; i < 1024; i++) begin
            dev_mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        for (int c = 0; c < 8; c++) sh_en[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ext_cs_n == 8'hFF, "R1 reset cs", ext_cs_n, 8'hFF);
        chk(!host_ack && ext_oe_n && ext_we_n && !ext_dq_oe, "R12 reset idle", host_ack, 0);
        access(1'b0, 32'h0000_0000, '0, 4'hF);            // R4 all disabled

        set_chan(0, 1, 1, 1, 0, 16'h000, 1, 2, 3, 1);      // 16-bit
        set_chan(1, 1, 2, 2, 2, 16'h010, 2, 1, 2, 2);      // 8-bit
        set_chan(2, 1, 0, 0, 4, 16'h020, 0, 0, 0, 0);      // 32-bit, all minimal
        for (int c = 3; c < 7; c++)
            set_chan(c, 1, int'($urandom % 3), int'($urandom % 4), int'($urandom % 5), c << 4,
                     int'($urandom % 4), int'($urandom % 4), int'($urandom % 16), int'($urandom % 4));

        // directed corners
        access(1'b1, 32'h0000_0010, 32'hA1B2C3D4, 4'b1100);   // R6 one sub-cycle at offset 2
        access(1'b0, 32'h0000_0010, '0, 4'hF);                // R5 two cycles
        access(1'b1, 32'h0100_0020, 32'h11223344, 4'hF);      // R5 four cycles
        access(1'b0, 32'h0100_0020, '0, 4'b0101);             // R6 lanes 1,3 zero
        access(1'b1, 32'h0200_0040, 32'hDEADBEEF, 4'h0);      // R6 no strobe
        access(1'b0, 32'h0200_0040, '0, 4'hF);                // R8 zero-length phases
        access(1'b0, 32'h0070_0000, '0, 4'hF);                // R4 disabled channel 7
        access(1'b0, 32'h0010_0000, '0, 4'hF);                // R2 just past 1 MB window of ch0
        access(1'b0, 32'hF000_0000, '0, 4'hF);                // R4 no window

        // R11: timing change in flight
        fork
            access(1'b0, 32'h0000_0008, '0, 4'hF);
            begin
                repeat (3) @(negedge clk);
                cfg_write(0, 1'b1, 32'(1) | 32'(2) << 2 | 32'(12) << 4 | 32'(1) << 8);
            end
        join
        sh_stw[0] = 12;
        access(1'b0, 32'h0000_0008, '0, 4'hF);                // R11 new width applies now

        // random traffic
        for (int t = 0; t < 300; t++) begin
            int c = int'($urandom % 7);
            logic [31:0] a = (32'(c) << 24) | (32'($urandom % 32) << 2);
            access(1'($urandom % 2), a, $urandom, 4'($urandom));
        end

        // R2 priority: ch7 overlaps ch2, lowest index wins
        set_chan(7, 1, 0, 0, 0, 16'h020, 0, 1, 1, 0);
        access(1'b0, 32'h0200_0040, '0, 4'hF);
        // R3 size cap: 8-bit channel with oversize code acts as 256 MB
        set_chan(7, 1, 2, 0, 15, 16'h800, 0, 0, 1, 0);
        access(1'b1, 32'h8FFF_FF04, 32'h55AA55AA, 4'hF);
        access(1'b0, 32'h8FFF_FF04, '0, 4'hF);
        access(1'b0, 32'h9000_0000, '0, 4'hF);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule